// File: doc/BRIEF.md
# Dual-CPU Doorbell Interrupt Unit

This block lets two processors ring each other's doorbell. Each of the two channels has a 4-bit status word and a level interrupt line. A channel's interrupt is high while any of its status bits is set. A processor rings a channel by writing ones to that channel's set port. The receiving processor acknowledges by writing ones to the channel's clear port. A simple 32-bit slave port reaches everything: a valid strobe, a write enable, a byte address, write data and read data.

The slave port decodes a 4 KB window. The channel registers sit at the bottom of the window and twelve read-only identification bytes sit at the top. When a cycle breaks the access rules, the block raises a one-cycle error pulse and the bus read data stays zero. The rules are broken by a read of a write-only port, a write to a read-only register, an unmapped offset or a misaligned address. A write that breaks the rules changes no state.

Top module: `dbell_unit`

## Requirements
- R1: After reset both status words are zero, both `irq` bits are low, `bus_rdata` is zero and `bus_err` is low.
- R2: A write to the set port (offset 0x04 for channel 0, 0x14 for channel 1) ORs `bus_wdata[3:0]` into that channel's status on the clock edge that samples the write.
- R3: A write to the clear port (offset 0x08 for channel 0, 0x18 for channel 1) clears every status bit whose `bus_wdata[3:0]` bit is one, on the edge that samples the write.
- R4: `bus_wdata[31:4]` never affects status.
- R5: `irq[c]` is registered and equals "status of channel c is nonzero" as it stood one clock earlier, so it changes one cycle after the status does.
- R6: A read of a status word (offset 0x00 for channel 0, 0x10 for channel 1) returns the status in bits [3:0] with zeros above. Read data is registered and appears in the cycle after the sampling edge. `bus_rdata` is zero in any cycle that does not follow an accepted read.
- R7: The twelve ID words at 0xFD0, 0xFD4 and so on up to 0xFFC read, in address order, as 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with zeros above.
- R8: Reads of the set and clear ports return zero and raise `bus_err`.
- R9: Writes to a status word or an ID word change nothing and raise `bus_err`.
- R10: An access is unmapped when it is misaligned (`bus_addr[1:0]` nonzero) or hits any offset not listed above. An unmapped read returns zero, an unmapped write changes nothing, and both raise `bus_err`.
- R11: `bus_err` is high for exactly the cycle after the edge that samples an illegal access, and it stays low for legal accesses.
- R12: The channels are independent: an access to one channel never alters the other channel's status or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle illegal-access pulse |
| irq | output | 2 | Per-channel level interrupt |

## Verification
The hardest situations to reach are illegal writes that land on live state. They include a write to a status word that already holds a nonzero value, and misaligned writes whose aligned offset is a set or clear port. A decode slip in either case would quietly change the status. The stimulus first loads both channels with distinct nonzero patterns and then sends each illegal write. It reads the status back and watches the interrupts, so any change shows at the ports. The one-cycle interrupt lag is checked by sampling `irq` both in the cycle right after a set or clear and in the cycle after that.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_STAT,
    ACC_SET,
    ACC_CLR,
    ACC_ID,
    ACC_BAD
  } acc_kind_e;

  localparam int ID_COUNT = 12;
  localparam int ID_W     = 8;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_CH   = 2,
  parameter int CH_IDX_W = 1
) (
  input  logic                bus_valid,
  input  logic [ADDR_W-1:0]   bus_addr,
  output acc_kind_e           kind,
  output logic [CH_IDX_W-1:0] ch_sel,
  output logic [3:0]          id_idx
);
  localparam logic [ADDR_W-5:0] CH_LIMIT = (ADDR_W-4)'(NUM_CH);
  localparam logic [3:0]        ID_BASE  = 4'd4;

  logic aligned;
  logic in_ch;
  logic in_id;

  always_comb begin
    aligned = (bus_addr[1:0] == 2'b00);
    in_ch   = (bus_addr[ADDR_W-1:4] < CH_LIMIT);
    in_id   = (&bus_addr[ADDR_W-1:6]) && (bus_addr[5:2] >= ID_BASE);
    ch_sel  = bus_addr[4 +: CH_IDX_W];
    id_idx  = bus_addr[5:2] - ID_BASE;
    kind    = ACC_NONE;
    if (bus_valid) begin
      if (!aligned) begin
        kind = ACC_BAD;
      end else if (in_ch) begin
        unique case (bus_addr[3:2])
          2'd0:    kind = ACC_STAT;
          2'd1:    kind = ACC_SET;
          2'd2:    kind = ACC_CLR;
          default: kind = ACC_BAD;
        endcase
      end else if (in_id) begin
        kind = ACC_ID;
      end else begin
        kind = ACC_BAD;
      end
    end
  end
endmodule

// File: rtl/dbell_id_rom.sv
module dbell_id_rom
  import dbell_pkg::*;
(
  input  logic [3:0]      idx,
  output logic [ID_W-1:0] val
);
  always_comb begin
    unique case (idx)
      4'd0:    val = 8'h04;
      4'd4:    val = 8'h56;
      4'd5:    val = 8'hB8;
      4'd6:    val = 8'h0B;
      4'd8:    val = 8'h0D;
      4'd9:    val = 8'hF0;
      4'd10:   val = 8'h05;
      4'd11:   val = 8'hB1;
      default: val = 8'h00;
    endcase
  end
endmodule

// File: rtl/dbell_channel.sv
module dbell_channel #(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] wmask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] status_q, status_d;
  logic              upd_en;
  logic              irq_q, irq_d;

  always_comb begin
    upd_en   = set_en | clr_en;
    status_d = status_q;
    if (set_en) status_d = status_d | wmask;
    if (clr_en) status_d = status_d & ~wmask;
    irq_d    = |status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (upd_en) status_q <= status_d;
      irq_q <= irq_d;
    end
  end

  assign status = status_q;
  assign irq    = irq_q;

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((status_q & $past(wmask)) == $past(wmask)));

  assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((status_q & $past(wmask)) == '0));

  assert_hold_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(status_q));

  assert_irq_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_q) != '0) |-> irq_q);
endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
  import dbell_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 2,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic [NUM_CH-1:0] irq
);
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  acc_kind_e           kind;
  logic [CH_IDX_W-1:0] ch_sel;
  logic [3:0]          id_idx;
  logic [ID_W-1:0]     id_val;

  dbell_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_dec (
    .bus_valid(bus_valid), .bus_addr(bus_addr),
    .kind(kind), .ch_sel(ch_sel), .id_idx(id_idx)
  );

  dbell_id_rom u_rom (.idx(id_idx), .val(id_val));

  logic [STAT_W-1:0] wmask;
  logic              unused_wdata;
  assign wmask        = bus_wdata[STAT_W-1:0];
  assign unused_wdata = ^bus_wdata[DATA_W-1:STAT_W];

  logic [STAT_W-1:0] stat_arr [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit, set_en, clr_en;
    assign hit    = (ch_sel == CH_IDX_W'(g)) && bus_we;
    assign set_en = hit && (kind == ACC_SET);
    assign clr_en = hit && (kind == ACC_CLR);
    dbell_channel #(.STAT_W(STAT_W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n),
      .set_en(set_en), .clr_en(clr_en), .wmask(wmask),
      .status(stat_arr[g]), .irq(irq[g])
    );
  end

  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              err_d, err_q;

  always_comb begin
    rdata_d = '0;
    if (!bus_we) begin
      if (kind == ACC_STAT) rdata_d[STAT_W-1:0] = stat_arr[ch_sel];
      if (kind == ACC_ID)   rdata_d[ID_W-1:0]   = id_val;
    end
    err_d = (kind == ACC_BAD)
          || (bus_we  && ((kind == ACC_STAT) || (kind == ACC_ID)))
          || (!bus_we && ((kind == ACC_SET)  || (kind == ACC_CLR)));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  assert_err_needs_access_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_err |-> $past(bus_valid));

  assert_rdata_idle_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_valid || bus_we) |=> (bus_rdata == '0));

  assert_write_no_rdata_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && bus_we) |=> (bus_rdata == '0));
endmodule

// File: tb/dbell_unit_tb_top.sv
module dbell_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [1:0]  irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dbell_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at negedge; sample registered results at the following negedge
  task automatic do_write(input logic [11:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
    err = bus_err;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic err);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata; err = bus_err;
  endtask

  function automatic logic [7:0] id_exp(input int i);
    case (i)
      0: return 8'h04;  4: return 8'h56;  5: return 8'hB8;  6: return 8'h0B;
      8: return 8'h0D;  9: return 8'hF0; 10: return 8'h05; 11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  task automatic t_reset;
    logic [31:0] d; logic e;
    check(irq == 2'b00, "R1 irq", {30'd0, irq}, 0);
    check(bus_err == 1'b0, "R1 err", {31'd0, bus_err}, 0);
    check(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    do_read(12'h000, d, e); check(d == 0 && !e, "R1 stat0", d, 0);
    do_read(12'h010, d, e); check(d == 0 && !e, "R1 stat1", d, 0);
  endtask

  task automatic t_set_irq;
    logic [31:0] d; logic e;
    do_write(12'h004, 32'h5, e);
    check(!e, "R2 set err", {31'd0, e}, 0);
    check(irq[0] == 1'b0, "R5 irq lag", {31'd0, irq[0]}, 0);
    check(bus_rdata == 0, "R6 rdata after write", bus_rdata, 0);
    @(negedge clk);
    check(irq[0] == 1'b1, "R5 irq rise", {31'd0, irq[0]}, 1);
    do_read(12'h000, d, e); check(d == 32'h5, "R2 stat0", d, 32'h5);
    check(bus_rdata == 32'h5, "R6 read data", bus_rdata, 32'h5);
    @(negedge clk);
    check(bus_rdata == 0, "R6 rdata idle", bus_rdata, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d; logic e;
    do_write(12'h004, 32'hFFFF_FFF2, e);
    do_read(12'h000, d, e); check(d == 32'h7, "R4 mask", d, 32'h7);
  endtask

  task automatic t_clear;
    logic [31:0] d; logic e;
    do_write(12'h008, 32'hFFFF_FF01, e);
    check(!e, "R3 clr err", {31'd0, e}, 0);
    do_read(12'h000, d, e); check(d == 32'h6, "R3 partial clear", d, 32'h6);
    do_write(12'h008, 32'hF, e);
    check(irq[0] == 1'b1, "R5 irq fall lag", {31'd0, irq[0]}, 1);
    @(negedge clk);
    check(irq[0] == 1'b0, "R5 irq fall", {31'd0, irq[0]}, 0);
    do_read(12'h000, d, e); check(d == 0, "R3 full clear", d, 0);
  endtask

  task automatic t_ch1;
    logic [31:0] d; logic e;
    do_write(12'h014, 32'hA, e);
    @(negedge clk);
    check(irq == 2'b10, "R12 irq vector", {30'd0, irq}, 32'h2);
    do_read(12'h010, d, e); check(d == 32'hA, "R2 stat1", d, 32'hA);
    do_read(12'h000, d, e); check(d == 0, "R12 ch0 untouched", d, 0);
    do_write(12'h004, 32'h3, e);
    do_write(12'h018, 32'h2, e);
    do_read(12'h000, d, e); check(d == 32'h3, "R12 ch0 after ch1 clr", d, 32'h3);
    do_read(12'h010, d, e); check(d == 32'h8, "R3 ch1 clr", d, 32'h8);
  endtask

  task automatic t_id;
    logic [31:0] d; logic e;
    for (int i = 0; i < 12; i++) begin
      do_read(12'hFD0 + 12'(4*i), d, e);
      check(d == {24'd0, id_exp(i)} && !e, "R7 id", d, {24'd0, id_exp(i)});
    end
  endtask

  task automatic t_wo_read;
    logic [31:0] d; logic e;
    logic [11:0] a[4] = '{12'h004, 12'h008, 12'h014, 12'h018};
    for (int i = 0; i < 4; i++) begin
      do_read(a[i], d, e);
      check(d == 0, "R8 wo data", d, 0);
      check(e, "R8 wo err", {31'd0, e}, 1);
    end
  endtask

  task automatic t_ro_write;
    logic [31:0] d; logic e;
    // ch0 = 0x3, ch1 = 0x8
    do_write(12'h010, 32'hF, e); check(e, "R9 stat write err", {31'd0, e}, 1);
    do_write(12'h000, 32'h0, e); check(e, "R9 stat write err", {31'd0, e}, 1);
    do_read(12'h010, d, e); check(d == 32'h8, "R9 ch1 held", d, 32'h8);
    do_read(12'h000, d, e); check(d == 32'h3, "R9 ch0 held", d, 32'h3);
    do_write(12'hFD0, 32'hFF, e); check(e, "R9 id write err", {31'd0, e}, 1);
    do_read(12'hFD0, d, e); check(d == 32'h04, "R9 id held", d, 32'h04);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic e;
    logic [11:0] ra[5] = '{12'h00C, 12'h020, 12'hFCC, 12'h800, 12'h002};
    logic [11:0] wa[4] = '{12'h00C, 12'h024, 12'h005, 12'h00A};
    for (int i = 0; i < 5; i++) begin
      do_read(ra[i], d, e);
      check(d == 0 && e, "R10 unmapped read", d, 0);
    end
    for (int i = 0; i < 4; i++) begin
      do_write(wa[i], 32'hF, e);
      check(e, "R10 unmapped write err", {31'd0, e}, 1);
    end
    do_read(12'h000, d, e); check(d == 32'h3, "R10 ch0 unchanged", d, 32'h3);
    do_read(12'h010, d, e); check(d == 32'h8, "R10 ch1 unchanged", d, 32'h8);
  endtask

  task automatic t_err_pulse;
    logic [31:0] d; logic e;
    do_read(12'h004, d, e);
    check(e, "R11 err high", {31'd0, e}, 1);
    @(negedge clk);
    check(bus_err == 1'b0, "R11 err one cycle", {31'd0, bus_err}, 0);
    do_read(12'hFFC, d, e);
    check(!e && d == 32'hB1, "R11 legal no err", d, 32'hB1);
  endtask

  initial begin
    bus_valid = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_irq();
    t_mask();
    t_clear();
    t_ch1();
    t_id();
    t_wo_read();
    t_ro_write();
    t_unmapped();
    t_err_pulse();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule